// File: doc/BRIEF.md
# Counter-Mode Block Generator

This block supplies the input blocks for a block cipher that runs in counter mode. Every block it emits joins three fields. The first is an identifier that is fixed for the instance. The second is a key-epoch counter, and the third is a per-block sequence counter. A consumer pulses a request and receives exactly one block on the next clock. When the cipher is given a fresh key, a key-update pulse moves the generator to a new epoch.

The generator never emits the same epoch/sequence pair twice within one reset session. When the sequence counter has used its last value, the epoch advances and the sequence restarts at zero. The generator then raises a key request and holds back further blocks until a new key is reported. The epoch counter can also run out. In that case a sticky exhaustion flag is raised and the generator stays silent until reset. Field widths are parameters; the defaults give 40 + 48 + 40 = 128 bits.

Top module: `ctr_block_gen`

## Requirements
- R1: `blk_o` holds, from most to least significant bit, the identifier field (ID_W bits), the epoch field (KEY_W bits) and the sequence field (SEQ_W bits).
- R2: The identifier field is the value on `cipher_id_i` at the last rising clock edge while `rst_n` was low. Changes on `cipher_id_i` after reset has been released have no effect on emitted blocks.
- R3: A request accepted in cycle t gives `blk_valid_o` high for exactly cycle t+1. `blk_valid_o` is low in every other cycle. A request is accepted only when the generator is running and `key_update_i` is low in the same cycle.
- R4: After reset the epoch and sequence are zero. Each emitted block with a sequence value below all-ones makes the next block's sequence one higher.
- R5: A key update while running advances the epoch by one and clears the sequence to zero. A request in the same cycle as the update is dropped.
- R6: An emitted block whose sequence field is all ones advances the epoch and clears the sequence. `key_req_o` goes high in the cycle that block is valid.
- R7: While `key_req_o` is high, requests are ignored. A key update clears `key_req_o` on the next cycle and does not advance the epoch again.
- R8: If the epoch must advance while it is all ones, `exhausted_o` goes high and stays high until reset. When that happens, `key_req_o` is low, no block is emitted and key updates are ignored.
- R9: While reset is asserted, `blk_o`, `blk_valid_o`, `key_req_o` and `exhausted_o` are all zero.
- R10: Within one reset session, the pair (epoch, sequence) of each valid block is strictly greater than the pair of the previous valid block, so no pair repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion; identifier captured while low |
| cipher_id_i | input | ID_W | Instance identifier, sampled during reset |
| key_update_i | input | 1 | One-cycle pulse: cipher has loaded a new key |
| next_req_i | input | 1 | One-cycle pulse: request the next counter block |
| blk_o | output | ID_W+KEY_W+SEQ_W | Counter block, held between pulses |
| blk_valid_o | output | 1 | One-cycle strobe marking a fresh `blk_o` |
| key_req_o | output | 1 | Sequence space used up; a new key is required |
| exhausted_o | output | 1 | Sticky: epoch space used up, generator halted |

## Verification
Several properties are checked on every cycle. Strobes occur only after requests, and none occurs while a key is being requested or after exhaustion. Exhaustion is sticky and never coincides with a key request. The epoch/sequence pair rises strictly from one valid block to the next, and the identifier field stays constant across blocks. Other behaviours need directed scenarios with small field widths: the identifier capture window, dropping a request that collides with an update, the exact epoch value after a wrap followed by a key update, and reaching epoch exhaustion.

// File: rtl/ctr_gen_pkg.sv
package ctr_gen_pkg;

   typedef enum logic [1:0] {
      SEQ_RUN      = 2'd0,
      SEQ_WAIT_KEY = 2'd1,
      SEQ_DEAD     = 2'd2
   } gen_state_e;

   function automatic int unsigned block_width(input int unsigned id_w,
                                               input int unsigned key_w,
                                               input int unsigned seq_w);
      return id_w + key_w + seq_w;
   endfunction

endpackage

// File: rtl/ctr_field_cnt.sv
module ctr_field_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o,
   output logic         at_max_o
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   initial begin
      if (W < 1) $fatal(1, "ctr_field_cnt: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o    = cnt_q;
   assign at_max_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/ctr_seq_ctrl.sv
module ctr_seq_ctrl
   import ctr_gen_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic key_update_i,
   input  logic next_req_i,
   input  logic seq_max_i,
   input  logic key_max_i,
   output logic emit_o,
   output logic seq_inc_o,
   output logic seq_clr_o,
   output logic key_inc_o,
   output logic key_req_o,
   output logic exhausted_o
);
   gen_state_e state_q, state_d;
   logic       upd_ok, seq_wrap, key_adv_need, key_fatal;

   always_comb begin
      upd_ok       = key_update_i && (state_q != SEQ_DEAD);
      emit_o       = next_req_i && !key_update_i && (state_q == SEQ_RUN);
      seq_wrap     = emit_o && seq_max_i;
      key_adv_need = seq_wrap || (upd_ok && (state_q == SEQ_RUN));
      key_fatal    = key_adv_need && key_max_i;
      key_inc_o    = key_adv_need && !key_max_i;
      seq_clr_o    = key_inc_o;
      seq_inc_o    = emit_o && !seq_max_i;

      state_d = state_q;
      if (key_fatal) begin
         state_d = SEQ_DEAD;
      end else if (seq_wrap) begin
         state_d = SEQ_WAIT_KEY;
      end else if (upd_ok && (state_q == SEQ_WAIT_KEY)) begin
         state_d = SEQ_RUN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEQ_RUN;
      else        state_q <= state_d;
   end

   assign key_req_o   = (state_q == SEQ_WAIT_KEY);
   assign exhausted_o = (state_q == SEQ_DEAD);
endmodule

// File: rtl/ctr_block_pack.sv
module ctr_block_pack #(
   parameter int unsigned ID_W  = 40,
   parameter int unsigned KEY_W = 48,
   parameter int unsigned SEQ_W = 40,
   parameter bit          HOLD_LAST = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         emit_i,
   input  logic [ID_W-1:0]              id_i,
   input  logic [KEY_W-1:0]             key_i,
   input  logic [SEQ_W-1:0]             seq_i,
   output logic [ID_W+KEY_W+SEQ_W-1:0]  blk_o,
   output logic                         valid_o
);
   localparam int unsigned TOT_W = ID_W + KEY_W + SEQ_W;

   logic [TOT_W-1:0] blk_q;
   logic             valid_q;
   logic [TOT_W-1:0] blk_next;

   assign blk_next = {id_i, key_i, seq_i};

   generate
      if (HOLD_LAST) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      blk_q <= '0;
            else if (emit_i) blk_q <= blk_next;
         end
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      blk_q <= '0;
            else             blk_q <= emit_i ? blk_next : '0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= emit_i;
   end

   assign blk_o   = blk_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/ctr_block_gen.sv
module ctr_block_gen
   import ctr_gen_pkg::*;
#(
   parameter int unsigned ID_W      = 40,
   parameter int unsigned KEY_W     = 48,
   parameter int unsigned SEQ_W     = 40,
   parameter bit          HOLD_LAST = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ID_W-1:0]             cipher_id_i,
   input  logic                        key_update_i,
   input  logic                        next_req_i,
   output logic [ID_W+KEY_W+SEQ_W-1:0] blk_o,
   output logic                        blk_valid_o,
   output logic                        key_req_o,
   output logic                        exhausted_o
);
   localparam int unsigned TOT_W = block_width(ID_W, KEY_W, SEQ_W);

   initial begin
      if (ID_W < 1)  $fatal(1, "ctr_block_gen: ID_W must be at least 1");
      if (KEY_W < 1) $fatal(1, "ctr_block_gen: KEY_W must be at least 1");
      if (SEQ_W < 1) $fatal(1, "ctr_block_gen: SEQ_W must be at least 1");
      if (TOT_W != ID_W + KEY_W + SEQ_W) $fatal(1, "ctr_block_gen: width mismatch");
   end

   // Identifier is loaded only while reset is held, then frozen.
   logic [ID_W-1:0] id_q;
   always_ff @(posedge clk) begin
      if (!rst_n) id_q <= cipher_id_i;
   end

   logic             emit, seq_inc, seq_clr, key_inc;
   logic             seq_max, key_max;
   logic [KEY_W-1:0] key_cnt;
   logic [SEQ_W-1:0] seq_cnt;

   ctr_seq_ctrl u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .key_update_i (key_update_i),
      .next_req_i   (next_req_i),
      .seq_max_i    (seq_max),
      .key_max_i    (key_max),
      .emit_o       (emit),
      .seq_inc_o    (seq_inc),
      .seq_clr_o    (seq_clr),
      .key_inc_o    (key_inc),
      .key_req_o    (key_req_o),
      .exhausted_o  (exhausted_o)
   );

   ctr_field_cnt #(.W(KEY_W)) u_key_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (key_inc),
      .clr_i    (1'b0),
      .cnt_o    (key_cnt),
      .at_max_o (key_max)
   );

   ctr_field_cnt #(.W(SEQ_W)) u_seq_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc_i    (seq_inc),
      .clr_i    (seq_clr),
      .cnt_o    (seq_cnt),
      .at_max_o (seq_max)
   );

   ctr_block_pack #(
      .ID_W      (ID_W),
      .KEY_W     (KEY_W),
      .SEQ_W     (SEQ_W),
      .HOLD_LAST (HOLD_LAST)
   ) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .emit_i  (emit),
      .id_i    (id_q),
      .key_i   (key_cnt),
      .seq_i   (seq_cnt),
      .blk_o   (blk_o),
      .valid_o (blk_valid_o)
   );
endmodule

// File: rtl/ctr_block_gen_chk.sv
module ctr_block_gen_chk #(
   parameter int unsigned ID_W  = 40,
   parameter int unsigned KEY_W = 48,
   parameter int unsigned SEQ_W = 40
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        key_update_i,
   input logic                        next_req_i,
   input logic [ID_W+KEY_W+SEQ_W-1:0] blk_o,
   input logic                        blk_valid_o,
   input logic                        key_req_o,
   input logic                        exhausted_o
);
   localparam int unsigned PAIR_W = KEY_W + SEQ_W;

   logic [PAIR_W-1:0] last_pair;
   logic [ID_W-1:0]   last_id;
   logic              seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_pair <= '0;
         last_id   <= '0;
         seen      <= 1'b0;
      end else if (blk_valid_o) begin
         last_pair <= blk_o[PAIR_W-1:0];
         last_id   <= blk_o[PAIR_W +: ID_W];
         seen      <= 1'b1;
      end
   end

   // R3: strobe only follows a request
   assert_valid_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid_o |-> $past(next_req_i) && !$past(key_update_i));

   // R7: no block while a key is requested
   assert_quiet_on_keyreq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      key_req_o |=> !blk_valid_o);

   // R8: exhaustion is sticky and silences output
   assert_exhaust_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted_o |=> exhausted_o && !blk_valid_o);

   assert_exhaust_no_keyreq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(exhausted_o && key_req_o));

   // R10: pair strictly increases between valid blocks
   assert_pair_rises_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid_o && seen) |-> (blk_o[PAIR_W-1:0] > last_pair));

   // R2: identifier field constant within a session
   assert_id_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_valid_o && seen) |-> (blk_o[PAIR_W +: ID_W] == last_id));
endmodule

bind ctr_block_gen ctr_block_gen_chk #(
   .ID_W  (ID_W),
   .KEY_W (KEY_W),
   .SEQ_W (SEQ_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .key_update_i (key_update_i),
   .next_req_i   (next_req_i),
   .blk_o        (blk_o),
   .blk_valid_o  (blk_valid_o),
   .key_req_o    (key_req_o),
   .exhausted_o  (exhausted_o)
);

// File: tb/ctr_block_gen_tb.sv
`timescale 1ns/1ps
module ctr_block_gen_tb;
   localparam int ID_W  = 8;
   localparam int KEY_W = 3;
   localparam int SEQ_W = 3;
   localparam int TOT_W = ID_W + KEY_W + SEQ_W;
   localparam int KMAX  = (1 << KEY_W) - 1;
   localparam int SMAX  = (1 << SEQ_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [ID_W-1:0]  cipher_id = '0;
   logic             key_update = 1'b0;
   logic             next_req = 1'b0;
   logic [TOT_W-1:0] blk;
   logic             blk_valid, key_req, exhausted;

   int checks = 0;
   int failures = 0;

   // reference model state
   int              m_kc, m_sc;
   bit              m_wait, m_dead, m_valid;
   logic [ID_W-1:0] m_id;
   logic [TOT_W-1:0] m_blk;

   always #2.5 clk = ~clk;

   ctr_block_gen #(.ID_W(ID_W), .KEY_W(KEY_W), .SEQ_W(SEQ_W)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .cipher_id_i  (cipher_id),
      .key_update_i (key_update),
      .next_req_i   (next_req),
      .blk_o        (blk),
      .blk_valid_o  (blk_valid),
      .key_req_o    (key_req),
      .exhausted_o  (exhausted)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_advance_key();
      if (m_kc == KMAX) begin
         m_dead = 1'b1;
         m_wait = 1'b0;
      end else begin
         m_kc++;
         m_sc = 0;
      end
   endtask

   task automatic model_clock(input bit req, input bit upd);
      bit emit;
      m_valid = 1'b0;
      if (m_dead) return;
      emit = req && !upd && !m_wait;
      if (emit) begin
         m_valid = 1'b1;
         m_blk = {m_id, KEY_W'(m_kc), SEQ_W'(m_sc)};
         if (m_sc == SMAX) begin
            model_advance_key();
            if (!m_dead) m_wait = 1'b1;
         end else begin
            m_sc++;
         end
      end else if (upd) begin
         if (m_wait) m_wait = 1'b0;
         else        model_advance_key();
      end
   endtask

   task automatic compare();
      string tag;
      chk(blk_valid == m_valid, "R3", blk_valid, m_valid);
      chk(key_req == m_wait, "R6", key_req, m_wait);
      chk(exhausted == m_dead, "R8", exhausted, m_dead);
      if (m_valid) begin
         if (blk[TOT_W-1 -: ID_W] != m_blk[TOT_W-1 -: ID_W]) tag = "R2";
         else if (blk[SEQ_W +: KEY_W] != m_blk[SEQ_W +: KEY_W]) tag = "R5";
         else if (blk[SEQ_W-1:0] != m_blk[SEQ_W-1:0]) tag = "R4";
         else tag = "R1";
         chk(blk == m_blk, tag, blk, m_blk);
      end
   endtask

   task automatic step(input bit req, input bit upd);
      next_req   = req;
      key_update = upd;
      @(posedge clk);
      model_clock(req, upd);
      @(negedge clk);
      compare();
   endtask

   task automatic do_reset(input logic [ID_W-1:0] id);
      @(negedge clk);
      rst_n = 1'b0;
      next_req = 1'b0;
      key_update = 1'b0;
      cipher_id = id;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: outputs idle in reset
      chk(blk == '0 && !blk_valid && !key_req && !exhausted, "R9",
          {blk_valid, key_req, exhausted}, 0);
      m_id = id; m_kc = 0; m_sc = 0; m_wait = 0; m_dead = 0; m_valid = 0;
      m_blk = '0;
      rst_n = 1'b1;
   endtask

   initial begin
      #(5.0 * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int pulses;
      logic [KEY_W-1:0] ep_before;

      do_reset(8'hA5);
      // R2: identifier change after reset must not matter
      cipher_id = 8'h3C;

      // R4: consecutive requests, sequence counts from zero
      for (int i = 0; i < 3; i++) step(1, 0);
      chk(blk[SEQ_W-1:0] == 3'd2 && blk[SEQ_W +: KEY_W] == 3'd0, "R4", blk, {8'hA5, 3'd0, 3'd2});
      step(0, 0);
      step(1, 0);

      // R5: update with colliding request is dropped, epoch advances
      step(1, 1);
      chk(!blk_valid, "R5", blk_valid, 0);
      step(1, 0);
      chk(blk[SEQ_W +: KEY_W] == 3'd1 && blk[SEQ_W-1:0] == 3'd0, "R5", blk, {8'hA5, 3'd1, 3'd0});

      // R6: run sequence to its last value
      while (!key_req && !exhausted) step(1, 0);
      chk(key_req && blk_valid && blk[SEQ_W-1:0] == 3'(SMAX), "R6", blk, SMAX);
      ep_before = blk[SEQ_W +: KEY_W];

      // R7: requests during key request are ignored
      pulses = 0;
      for (int i = 0; i < 4; i++) begin
         step(1, 0);
         if (blk_valid) pulses++;
      end
      chk(pulses == 0, "R7", pulses, 0);
      step(0, 1);
      chk(!key_req, "R7", key_req, 0);
      step(1, 0);
      chk(blk[SEQ_W +: KEY_W] == KEY_W'(ep_before + 1) && blk[SEQ_W-1:0] == '0, "R7",
          blk[SEQ_W +: KEY_W], ep_before + 1);

      // mixed traffic until exhaustion
      for (int i = 0; i < 2000 && !m_dead; i++) begin
         bit r, u;
         r = ($urandom % 4) != 0;
         u = ($urandom % 9) == 0;
         if (m_wait) u = ($urandom % 3) == 0;
         step(r, u);
      end
      chk(exhausted, "R8", exhausted, 1);

      // R8: nothing moves after exhaustion
      pulses = 0;
      for (int i = 0; i < 6; i++) begin
         step(1, i[0]);
         if (blk_valid || !exhausted || key_req) pulses++;
      end
      chk(pulses == 0, "R8", pulses, 0);

      // fresh session with another identifier
      do_reset(8'h5A);
      step(1, 0);
      chk(blk == {8'h5A, 3'd0, 3'd0}, "R1", blk, {8'h5A, 3'd0, 3'd0});
      for (int i = 0; i < 40; i++) step(($urandom % 2) == 1, ($urandom % 7) == 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule